// File: doc/BRIEF.md
# Programmable CRC Engine with Reshaping Input FIFO

This block computes a cyclic redundancy check over a stream of data words that software writes through a small register bus. The polynomial order (1 to 32), the feedback taps, the data word width (8, 16 or 32 bits) and the bit order are all programmed separately. Words go into an input FIFO with a fixed 128-bit store. The FIFO holds 16 bytes, 8 half-words or 4 words, depending on the width. A shift buffer takes a word from the FIFO and feeds it into the CRC register at two bits per clock. The remainder can be seeded beforehand and read back at any time.

The bus has no back-pressure. A data write is accepted in the cycle it is presented, or it is dropped when the FIFO is full. Software therefore has to watch the full flag, or depend on the sticky overflow flag to learn about a loss. The interrupt line is a sticky flag. It is set either when the FIFO runs empty or when a word finishes shifting, and software clears it by writing a one.

Register map (16-bit bus, `bus_addr`):
- 0 control: [0] run, [1] LSB-first, [2] interrupt on word done (0 = on FIFO empty), [4:3] width (0 = 8, 1 = 16, 2 or 3 = 32), [12:8] order minus one.
- 1 status: [0] FIFO empty, [1] FIFO full, [2] overflow, [3] busy, [4] interrupt flag. A write of one to bit 2 or bit 4 clears that flag.
- 2 and 3: polynomial taps, low and high halves.
- 4 and 5: data. In 8-bit and 16-bit mode a write to 4 pushes its low bits. In 32-bit mode a write to 4 holds the low half and a write to 5 pushes {write data, held half}.
- 6 and 7: remainder, low and high halves. A write loads a seed and a read returns the current value.

Top module: `crc_engine`

## Requirements
- R1: After reset, status reads 0x0001 (only the empty bit set), control reads 0, the remainder reads 0 and `irq` is low.
- R2: In MSB-first mode, each data bit d updates the remainder c of order n like this: the feedback is c[n-1] xor d, c shifts left by one and is truncated to n bits, and when the feedback is one it is xored with the taps (polynomial bit i set means tap i is enabled). The remainder starts from the seed.
- R3: With control bit 1 set, each word enters the remainder LSB first instead of MSB first.
- R4: The FIFO reports full after 16, 8 or 4 writes are pending for a width of 8, 16 or 32 bits, and not one write earlier.
- R5: A data write while the FIFO is full is dropped and sets the sticky overflow flag. The flag stays set until software writes one to status bit 2.
- R6: The interrupt flag is set in the cycle that empties the FIFO (control bit 2 = 0) or on the final shift step of a word (control bit 2 = 1). It stays set until software writes one to status bit 4.
- R7: Remainder bits at positions n and above always read as zero, including the bits of a seed that was just loaded.
- R8: While busy (the FIFO is not empty, or a word is still shifting), writes to the polynomial, the seed and all control fields except run are ignored.
- R9: The engine processes two bits per clock. A 32-bit word written while the engine is running and idle keeps busy high for exactly 17 clock cycles after the pushing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench fills the FIFO to its exact depth in all three widths and then writes one word more. A FIFO with the wrong depth, or one that overwrote data, would show the wrong full flag or the wrong remainder. It checks when the interrupt fires in each mode, one cycle after the push. A swapped select would raise the flag while shifting is still going on, or only after it ends. It tries to change the polynomial, the order and the seed while words are pending. A design that let those writes through would give a different readback and a different remainder. It measures busy cycle by cycle, which catches an engine that runs one bit per clock. Random orders, taps, seeds, widths and bit orders are checked against a bitwise reference model. This catches masking, tap-position and bit-order mistakes.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W = 32;

  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_STAT    = 3'd1,
    A_POLY_LO = 3'd2,
    A_POLY_HI = 3'd3,
    A_DATA_LO = 3'd4,
    A_DATA_HI = 3'd5,
    A_RES_LO  = 3'd6,
    A_RES_HI  = 3'd7
  } reg_addr_e;

  // n-bit mask where n = ord_m1 + 1
  function automatic logic [CRC_W-1:0] order_mask(input logic [4:0] ord_m1);
    logic [CRC_W:0] m;
    m = ({{CRC_W{1'b0}}, 1'b1} << ({1'b0, ord_m1} + 6'd1)) - 1'b1;
    return m[CRC_W-1:0];
  endfunction

  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic d,
                                               input logic [CRC_W-1:0] taps,
                                               input logic [4:0] ord_m1);
    logic [CRC_W-1:0] mask, nxt;
    logic fb;
    mask = order_mask(ord_m1);
    fb   = c[ord_m1] ^ d;
    nxt  = (c << 1) & mask;
    if (fb) nxt = nxt ^ (taps & mask);
    return nxt;
  endfunction

  function automatic logic [5:0] width_bits(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/crc_fifo.sv
module crc_fifo #(
  parameter int DW      = 32,
  parameter int ENTRIES = 16,
  localparam int AW = $clog2(ENTRIES),
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] limit,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [ENTRIES];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == limit);
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/crc_shifter.sv
module crc_shifter
  import crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CRC_W-1:0] word,
  input  logic [5:0]       wbits,
  input  logic             lsb_first,
  input  logic [CRC_W-1:0] taps,
  input  logic [4:0]       ord_m1,
  input  logic             seed_we_lo,
  input  logic             seed_we_hi,
  input  logic [15:0]      seed,
  output logic [CRC_W-1:0] crc,
  output logic             shifting,
  output logic             last
);
  logic [CRC_W-1:0] sbuf, aligned, rev;
  logic [4:0]       cnt;
  logic [CRC_W-1:0] step1, step2;

  always_comb begin
    for (int i = 0; i < CRC_W; i++) rev[i] = word[CRC_W-1-i];
    aligned = lsb_first ? rev : (word << (6'(CRC_W) - wbits));
  end

  assign step1 = crc_bit(crc, sbuf[CRC_W-1], taps, ord_m1);
  assign step2 = crc_bit(step1, sbuf[CRC_W-2], taps, ord_m1);
  assign last  = shifting && (cnt == 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbuf     <= '0;
      cnt      <= '0;
      shifting <= 1'b0;
      crc      <= '0;
    end else begin
      if (shifting) crc <= step2;
      else begin
        if (seed_we_lo) crc[15:0]  <= seed;
        if (seed_we_hi) crc[31:16] <= seed;
      end
      if (load) begin
        sbuf     <= aligned;
        cnt      <= wbits[5:1];
        shifting <= 1'b1;
      end else if (shifting) begin
        sbuf <= sbuf << 2;
        cnt  <= cnt - 1'b1;
        if (last) shifting <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int FIFO_BITS = 128,
  localparam int ENTRIES = FIFO_BITS / 8,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  logic             cfg_run, cfg_lsb, cfg_irq_done;
  logic [1:0]       cfg_wsel;
  logic [4:0]       cfg_plen;
  logic [CRC_W-1:0] cfg_poly;
  logic [15:0]      held_lo;
  logic             ovf_flag;

  logic             fifo_full, fifo_empty, push, pop, data_wr, wide;
  logic [CRC_W-1:0] fifo_din, fifo_dout, crc, crc_masked;
  logic [CW-1:0]    limit;
  logic [5:0]       wbits;
  logic             shifting, last, engaged, empty_evt, irq_set;

  assign wbits   = width_bits(cfg_wsel);
  assign wide    = (wbits == 6'd32);
  assign limit   = CW'(ENTRIES) >> ((cfg_wsel == 2'd3) ? 2'd2 : cfg_wsel);
  assign engaged = shifting || !fifo_empty;

  assign data_wr  = bus_we && ((bus_addr == A_DATA_LO && !wide) || (bus_addr == A_DATA_HI && wide));
  assign push     = data_wr && !fifo_full;
  assign fifo_din = wide ? {bus_wdata, held_lo}
                         : (wbits == 6'd16) ? {16'h0, bus_wdata} : {24'h0, bus_wdata[7:0]};
  assign pop      = cfg_run && !fifo_empty && (!shifting || last);

  crc_fifo #(.DW(CRC_W), .ENTRIES(ENTRIES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(fifo_din),
    .limit(limit), .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
  );

  crc_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(pop), .word(fifo_dout), .wbits(wbits),
    .lsb_first(cfg_lsb), .taps(cfg_poly), .ord_m1(cfg_plen),
    .seed_we_lo(bus_we && bus_addr == A_RES_LO && !engaged),
    .seed_we_hi(bus_we && bus_addr == A_RES_HI && !engaged),
    .seed(bus_wdata), .crc(crc), .shifting(shifting), .last(last)
  );

  // FIFO-empty event: the pop that removes the last pending word
  logic [CW-1:0] pending;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else if (push && !pop) pending <= pending + 1'b1;
    else if (pop && !push) pending <= pending - 1'b1;
  end
  assign empty_evt = pop && !push && (pending == CW'(1));
  assign irq_set   = cfg_irq_done ? last : empty_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_run <= 1'b0; cfg_lsb <= 1'b0; cfg_irq_done <= 1'b0;
      cfg_wsel <= '0; cfg_plen <= '0; cfg_poly <= '0;
      held_lo <= '0; ovf_flag <= 1'b0; irq <= 1'b0;
    end else begin
      if (bus_we && bus_addr == A_CTRL) begin
        cfg_run <= bus_wdata[0];
        if (!engaged) begin
          cfg_lsb      <= bus_wdata[1];
          cfg_irq_done <= bus_wdata[2];
          cfg_wsel     <= bus_wdata[4:3];
          cfg_plen     <= bus_wdata[12:8];
        end
      end
      if (bus_we && bus_addr == A_POLY_LO && !engaged) cfg_poly[15:0]  <= bus_wdata;
      if (bus_we && bus_addr == A_POLY_HI && !engaged) cfg_poly[31:16] <= bus_wdata;
      if (bus_we && bus_addr == A_DATA_LO) held_lo <= bus_wdata;
      ovf_flag <= (data_wr && fifo_full) ||
                  (ovf_flag && !(bus_we && bus_addr == A_STAT && bus_wdata[2]));
      irq <= irq_set || (irq && !(bus_we && bus_addr == A_STAT && bus_wdata[4]));
    end
  end

  assign crc_masked = crc & order_mask(cfg_plen);

  always_comb begin
    case (bus_addr)
      A_CTRL:    bus_rdata = {3'b0, cfg_plen, 3'b0, cfg_wsel, cfg_irq_done, cfg_lsb, cfg_run};
      A_STAT:    bus_rdata = {11'b0, irq, engaged, ovf_flag, fifo_full, fifo_empty};
      A_POLY_LO: bus_rdata = cfg_poly[15:0];
      A_POLY_HI: bus_rdata = cfg_poly[31:16];
      A_RES_LO:  bus_rdata = crc_masked[15:0];
      A_RES_HI:  bus_rdata = crc_masked[31:16];
      default:   bus_rdata = 16'h0;
    endcase
  end
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        irq,
  input logic        fifo_full,
  input logic        fifo_empty,
  input logic        ovf,
  input logic        irq_on_done,
  input logic        engaged,
  input logic [4:0]  plen,
  input logic [31:0] poly
);
  assert_full_empty_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(bus_we && bus_addr == 3'd1 && bus_wdata[2])) |=> ovf);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_we && bus_addr == 3'd1 && bus_wdata[4])) |=> irq);

  assert_irq_on_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_on_done && $rose(irq)) |-> fifo_empty);

  assert_order_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    engaged |=> ($stable(plen) && $stable(poly)));
endmodule

bind crc_engine crc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq(irq), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .ovf(ovf_flag),
  .irq_on_done(cfg_irq_done), .engaged(engaged), .plen(cfg_plen), .poly(cfg_poly)
);

// File: tb/crc_engine_test.sv
module crc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crc_engine uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] ref_mask(int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] c, logic [31:0] w, int wb, bit lsb,
                                           logic [31:0] p, int n);
    logic d, fb;
    for (int i = 0; i < wb; i++) begin
      d  = lsb ? w[i] : w[wb-1-i];
      fb = c[n-1] ^ d;
      c  = (c << 1) & ref_mask(n);
      if (fb) c = c ^ (p & ref_mask(n));
    end
    return c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_res(output logic [31:0] r);
    logic [15:0] lo, hi;
    rd(3'd6, lo); rd(3'd7, hi);
    r = {hi, lo};
  endtask

  task automatic push(logic [31:0] w, int wb);
    if (wb == 32) begin wr(3'd4, w[15:0]); wr(3'd5, w[31:16]); end
    else wr(3'd4, w[15:0]);
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(3'd1, s);
      if (!s[3]) break;
    end
  endtask

  function automatic logic [15:0] ctrl(bit run, bit lsb, bit idone, int wsel, int plen);
    return {3'b0, 5'(plen), 3'b0, 2'(wsel), idone, lsb, run};
  endfunction

  initial begin
    logic [15:0] s;
    logic [31:0] r, exp, w, p, seed;
    int wsel, wb, n, nw;
    bit lsb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd1, s); check("R1 status", s, 16'h0001);
    rd(3'd0, s); check("R1 ctrl", s, 16'h0000);
    rd_res(r);   check("R1 result", r, 32'h0);
    check("R1 irq", irq, 1'b0);

    // R7 seed readback masked to order 8
    wr(3'd0, ctrl(0, 0, 0, 2, 7));
    wr(3'd6, 16'h1234); wr(3'd7, 16'hABCD);
    rd_res(r); check("R7 masked seed", r, 32'h0000_0034);

    // R9 two bits per clock: 32-bit word, 17 busy cycles
    wr(3'd0, ctrl(1, 0, 1, 2, 31));
    wr(3'd4, 16'h5A5A); wr(3'd5, 16'hC3C3);
    bus_addr = 3'd1;
    repeat (16) @(negedge clk);
    #1 check("R9 busy at cycle 16", bus_rdata[3], 1'b1);
    @(negedge clk);
    #1 check("R9 idle at cycle 17", bus_rdata[3], 1'b0);

    // R6 interrupt on FIFO empty: set one cycle after push, while shifting
    wr(3'd0, ctrl(0, 0, 0, 2, 15));
    wr(3'd1, 16'h0014);
    wr(3'd0, ctrl(1, 0, 0, 2, 15));
    wr(3'd4, 16'h1111); wr(3'd5, 16'h2222);
    rd(3'd1, s); check("R6 empty-mode status", s, 16'h0019);
    check("R6 irq pin", irq, 1'b1);
    wait_idle();
    wr(3'd1, 16'h0010);
    rd(3'd1, s); check("R6 irq cleared", s[4], 1'b0);
    // R6 interrupt on word done: not yet set while shifting
    wr(3'd0, ctrl(1, 0, 1, 2, 15));
    wr(3'd4, 16'h1111); wr(3'd5, 16'h2222);
    rd(3'd1, s); check("R6 done-mode status", s, 16'h0009);
    wait_idle();
    rd(3'd1, s); check("R6 done-mode set", s, 16'h0011);
    wr(3'd1, 16'h0010);

    // R4 depth per width, R5 overflow drop
    for (int ws = 0; ws < 3; ws++) begin
      int depth;
      wb = (ws == 0) ? 8 : (ws == 1) ? 16 : 32;
      depth = 128 / wb;
      wr(3'd0, ctrl(0, 0, 0, ws, wb - 1));
      wr(3'd2, 16'h8005); wr(3'd3, 16'h04C1);
      wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
      p = 32'h04C1_8005; exp = 32'hFFFF_FFFF & ref_mask(wb);
      for (int i = 0; i < depth - 1; i++) begin
        w = $urandom & ref_mask(wb);
        push(w, wb); exp = ref_word(exp, w, wb, 0, p, wb);
      end
      rd(3'd1, s); check("R4 not full one short", s, 16'h0008);
      w = $urandom & ref_mask(wb);
      push(w, wb); exp = ref_word(exp, w, wb, 0, p, wb);
      rd(3'd1, s); check("R4 full at depth", s, 16'h000A);
      push(32'hFFFF_FFFF & ref_mask(wb), wb);
      rd(3'd1, s); check("R5 overflow set", s, 16'h000E);
      wr(3'd1, 16'h0004);
      rd(3'd1, s); check("R5 overflow cleared", s, 16'h000A);
      wr(3'd0, ctrl(1, 0, 0, ws, wb - 1));
      wait_idle();
      rd_res(r); check("R5 dropped word absent", r, exp);
      wr(3'd1, 16'h0010);
    end

    // R8 config frozen while words pending
    wr(3'd0, ctrl(0, 0, 0, 1, 15));
    wr(3'd2, 16'h1021); wr(3'd3, 16'h0000);
    wr(3'd6, 16'hFFFF);
    push(32'h0000_3132, 16);
    wr(3'd2, 16'hFFFF);
    wr(3'd0, ctrl(0, 1, 1, 0, 3));
    wr(3'd6, 16'h0000);
    rd(3'd2, s); check("R8 poly held", s, 16'h1021);
    rd(3'd0, s); check("R8 ctrl held", s, ctrl(0, 0, 0, 1, 15));
    wr(3'd0, ctrl(1, 0, 0, 1, 15));
    wait_idle();
    exp = ref_word(32'hFFFF, 32'h3132, 16, 0, 32'h1021, 16);
    rd_res(r); check("R8 seed and order held", r, exp);

    // R2/R3/R7 random configurations against the reference
    for (int it = 0; it < 40; it++) begin
      wsel = $urandom % 3;
      wb   = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
      n    = 1 + ($urandom % 32);
      p    = $urandom; seed = $urandom;
      lsb  = 1'($urandom % 2);
      nw   = 1 + ($urandom % (128 / wb));
      wait_idle();
      wr(3'd0, ctrl(0, lsb, 0, wsel, n - 1));
      wr(3'd2, p[15:0]); wr(3'd3, p[31:16]);
      wr(3'd6, seed[15:0]); wr(3'd7, seed[31:16]);
      exp = seed & ref_mask(n);
      if (it % 2 == 1) wr(3'd0, ctrl(1, lsb, 0, wsel, n - 1));
      for (int k = 0; k < nw; k++) begin
        w = $urandom & ref_mask(wb);
        push(w, wb);
        exp = ref_word(exp, w, wb, lsb, p, n);
      end
      wr(3'd0, ctrl(1, lsb, 0, wsel, n - 1));
      wait_idle();
      rd_res(r);
      if (lsb) check("R3 lsb-first remainder", r, exp);
      else     check("R2 msb-first remainder", r, exp);
      check("R7 high bits zero", r & ~ref_mask(n), 32'h0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule